// File: doc/BRIEF.md
# Backplane Slot Address Window Decoder

This block sits inside one plug-in module on an eight-slot backplane with a 32-bit address bus. It sorts every bus address into a region: physical memory, the shared global I/O area, the position-independent local I/O area, one of the eight per-slot I/O windows, or an unmapped I/O address. From that it raises a hit when the module has to answer. The module answers in three cases: the address falls in its own slot window, the address is in local I/O, or the address matches a software-programmed range compare. The slot number comes from a strap input.

The range compare is held in one 32-bit register that a simple write strobe loads. The upper half is the match value. The low fifteen bits choose which of address bits 30:16 take part in the compare, and bit 15 both includes address bit 31 and enables the compare. The block also turns a host CPU address into its bus I/O address, and a bus I/O address back into the host view, with one XOR. A combinational hit is provided, together with a copy of the hit registered one cycle later.

Top module: `slot_window_decoder`

## Requirements
- R1: `region_oh` is always one-hot, with bits {unmapped, slot, local, global, mem} from bit 4 down to bit 0. Addresses with bit 31 clear are mem.
- R2: Addresses 0x8000_0000 to 0x87FF_FFFF are global. Addresses 0x8800_0000 to 0x8FFF_FFFF are local. Addresses 0xA000_0000 and above are unmapped.
- R3: Addresses 0x9000_0000 to 0x9FFF_FFFF are slot windows of 32 MB each. `slot_idx` gives the window number, which is address bits 27:25.
- R4: `own_hit` is 1 exactly when the address is in a slot window whose number equals `slot_id`.
- R5: `reg_page` is 1 exactly when `own_hit` is 1 and the window offset (address bits 24:0) is 0x1FF_FE00 or above.
- R6: `range_hit` is 1 when range register bit 15 is 1, address bit 31 equals register bit 31, and address bit 16+i equals register bit 16+i for every i in 0..14 where register bit i is 1. Address bits whose register mask bit is 0 are ignored.
- R7: The range register resets to 0, so `range_hit` is 0 after reset whatever the address.
- R8: A rising clock edge with `cfg_we` high loads `cfg_wdata` into the range register. With `cfg_we` low the register keeps its value.
- R9: `hit` = local | `own_hit` | `range_hit`. `hit_q` equals `hit` from the previous clock edge and is 0 in reset.
- R10: `host_to_bus` = `host_addr` XOR 0xA000_0000, and `bus_to_host` = `bus_addr` XOR 0xA000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Bus address to decode |
| slot_id | input | 3 | Strapped slot number of this module |
| cfg_we | input | 1 | Range register write strobe |
| cfg_wdata | input | 32 | Range register write data |
| host_addr | input | 32 | Host CPU address to remap |
| region_oh | output | 5 | One-hot region {unmapped, slot, local, global, mem} |
| slot_idx | output | 3 | Slot window number of `bus_addr` |
| own_hit | output | 1 | Address is in this module's slot window |
| reg_page | output | 1 | Address is in the common register page of the own window |
| range_hit | output | 1 | Programmed range compare matches |
| hit | output | 1 | Module must answer (combinational) |
| hit_q | output | 1 | `hit` registered one cycle |
| host_to_bus | output | 32 | Host address converted to bus view |
| bus_to_host | output | 32 | Bus address converted to host view |

## Verification
The region decode is driven with the first and last address of every region, and with slot window addresses inside and outside the strapped slot. This separates off-by-one boundary errors from wrong bit selection. The register page is probed on both sides of its lower boundary, and in a foreign window where the offset bits alone would match. The range compare is tried with a full mask, with a partial mask, and with the enable bit clear, to show that it ignores unmasked bits and obeys the enable. Writes with the strobe low, and a reset applied after the range was programmed to match everything, show that the register holds its value and that it clears.

// File: rtl/swd_pkg.sv
package swd_pkg;
    localparam int ADDR_W  = 32;
    localparam int SLOT_W  = 3;
    localparam int REG_W   = 32;
    localparam int MASK_LO = 16;               // first address bit in range compare
    localparam int MASK_W  = 15;               // address bits 30:16
    localparam int WIN_LSB = 25;               // 32 MB windows
    localparam int REGION_N = 5;

    localparam logic [ADDR_W-1:0] REMAP_KEY = 32'hA000_0000;
    localparam logic [WIN_LSB-1:0] PAGE_BASE = 25'h1FF_FE00;

    typedef enum logic [2:0] {
        RG_MEM      = 3'd0,
        RG_GLOBAL   = 3'd1,
        RG_LOCAL    = 3'd2,
        RG_SLOT     = 3'd3,
        RG_UNMAPPED = 3'd4
    } region_e;
endpackage

// File: rtl/swd_region_classify.sv
module swd_region_classify
    import swd_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic [SLOT_W-1:0]   slot_id,
    output logic [REGION_N-1:0] region_oh,
    output logic [SLOT_W-1:0]   slot_idx,
    output logic                own_hit,
    output logic                reg_page
);
    region_e rg;

    always_comb begin
        unique case ({addr[31], addr[30:28]}) inside
            4'b0???: rg = RG_MEM;
            4'b1000: rg = addr[27] ? RG_LOCAL : RG_GLOBAL;
            4'b1001: rg = RG_SLOT;
            default: rg = RG_UNMAPPED;
        endcase
    end

    always_comb begin
        region_oh = '0;
        region_oh[rg] = 1'b1;
        slot_idx  = addr[WIN_LSB +: SLOT_W];
        own_hit   = (rg == RG_SLOT) && (slot_idx == slot_id);
        reg_page  = own_hit && (addr[WIN_LSB-1:0] >= PAGE_BASE);
    end
endmodule

// File: rtl/swd_range_match.sv
module swd_range_match
    import swd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  range_cfg,
    output logic              range_hit
);
    localparam int EN_BIT = MASK_W;            // bit 15 doubles as enable
    logic [MASK_W-1:0] bit_ok;

    genvar i;
    generate
        for (i = 0; i < MASK_W; i++) begin : g_cmp
            assign bit_ok[i] = !range_cfg[i] ||
                               (addr[MASK_LO+i] == range_cfg[MASK_LO+i]);
        end
    endgenerate

    assign range_hit = range_cfg[EN_BIT] &&
                       (addr[ADDR_W-1] == range_cfg[REG_W-1]) &&
                       (&bit_ok);
endmodule

// File: rtl/swd_addr_remap.sv
module swd_addr_remap
    import swd_pkg::*;
(
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] host_to_bus,
    output logic [ADDR_W-1:0] bus_to_host
);
    assign host_to_bus = host_addr ^ REMAP_KEY;
    assign bus_to_host = bus_addr ^ REMAP_KEY;
endmodule

// File: rtl/slot_window_decoder.sv
module slot_window_decoder
    import swd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [31:0]         bus_addr,
    input  logic [2:0]          slot_id,
    input  logic                cfg_we,
    input  logic [31:0]         cfg_wdata,
    input  logic [31:0]         host_addr,
    output logic [4:0]          region_oh,
    output logic [2:0]          slot_idx,
    output logic                own_hit,
    output logic                reg_page,
    output logic                range_hit,
    output logic                hit,
    output logic                hit_q,
    output logic [31:0]         host_to_bus,
    output logic [31:0]         bus_to_host
);
    logic [REG_W-1:0] range_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= '0;
            hit_q   <= 1'b0;
        end else begin
            if (cfg_we) range_q <= cfg_wdata;
            hit_q <= hit;
        end
    end

    swd_region_classify u_cls (
        .addr(bus_addr), .slot_id(slot_id), .region_oh(region_oh),
        .slot_idx(slot_idx), .own_hit(own_hit), .reg_page(reg_page)
    );

    swd_range_match u_rng (
        .addr(bus_addr), .range_cfg(range_q), .range_hit(range_hit)
    );

    swd_addr_remap u_map (
        .host_addr(host_addr), .bus_addr(bus_addr),
        .host_to_bus(host_to_bus), .bus_to_host(bus_to_host)
    );

    assign hit = region_oh[RG_LOCAL] | own_hit | range_hit;
endmodule

// File: rtl/slot_window_chk.sv
module slot_window_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] region_oh,
    input logic       own_hit,
    input logic       reg_page,
    input logic       range_hit,
    input logic       hit,
    input logic       hit_q
);
    AST_REGION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(region_oh) == 1); // R1
    AST_OWN_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        own_hit |-> region_oh[3]); // R4
    AST_PAGE_IN_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        reg_page |-> own_hit); // R5
    AST_RANGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !range_hit); // R7
    AST_HITQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> hit_q); // R9
    AST_HITQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !hit_q); // R9
endmodule

bind slot_window_decoder slot_window_chk u_chk (
    .clk(clk), .rst_n(rst_n), .region_oh(region_oh), .own_hit(own_hit),
    .reg_page(reg_page), .range_hit(range_hit), .hit(hit), .hit_q(hit_q)
);

// File: tb/tb_slot_window_decoder.sv
module tb_slot_window_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [2:0]  slot_id = 3'd3;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] host_addr = '0;
    logic [4:0]  region_oh;
    logic [2:0]  slot_idx;
    logic        own_hit, reg_page, range_hit, hit, hit_q;
    logic [31:0] host_to_bus, bus_to_host;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    slot_window_decoder dut (.*);

    // {addr, region {unm,slot,loc,glob,mem}, slot_idx, own, page}; slot_id = 3, range off
    localparam int NV = 13;
    localparam logic [41:0] VEC [NV] = '{
        {32'h0000_0000, 5'b00001, 3'd0, 1'b0, 1'b0},
        {32'h7FFF_FFFF, 5'b00001, 3'd7, 1'b0, 1'b0},
        {32'h8000_0000, 5'b00010, 3'd0, 1'b0, 1'b0},
        {32'h87FF_FFFF, 5'b00010, 3'd3, 1'b0, 1'b0},
        {32'h8800_0000, 5'b00100, 3'd4, 1'b0, 1'b0},
        {32'h8FFF_FFFF, 5'b00100, 3'd7, 1'b0, 1'b0},
        {32'h9000_0000, 5'b01000, 3'd0, 1'b0, 1'b0},
        {32'h9600_0000, 5'b01000, 3'd3, 1'b1, 1'b0},
        {32'h97FF_FE00, 5'b01000, 3'd3, 1'b1, 1'b1},
        {32'h97FF_FDFC, 5'b01000, 3'd3, 1'b1, 1'b0},
        {32'h9FFF_FFFF, 5'b01000, 3'd7, 1'b0, 1'b0},
        {32'hA000_0000, 5'b10000, 3'd0, 1'b0, 1'b0},
        {32'hFFFF_FFFF, 5'b10000, 3'd7, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic set_addr(input logic [31:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
    endtask

    task automatic write_range(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset hit_q", {31'd0, hit_q}, 32'd0);
        rst_n = 1'b1;
        set_addr(32'h0000_0000);
        chk("R7 range off after reset", {31'd0, range_hit}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            set_addr(VEC[i][41:10]);
            chk("R1 R2 region", {27'd0, region_oh}, {27'd0, VEC[i][9:5]});
            if (VEC[i][8]) chk("R3 slot_idx", {29'd0, slot_idx}, {29'd0, VEC[i][4:2]});
            chk("R4 own_hit", {31'd0, own_hit}, {31'd0, VEC[i][1]});
            chk("R5 reg_page", {31'd0, reg_page}, {31'd0, VEC[i][0]});
            chk("R9 hit", {31'd0, hit}, {31'd0, VEC[i][7] | VEC[i][1]});
            chk("R6 no range", {31'd0, range_hit}, 32'd0);
        end

        // R4 other strap
        slot_id = 3'd7;
        set_addr(32'h9E00_0000);
        chk("R4 own slot7", {31'd0, own_hit}, 32'd1);
        set_addr(32'h9600_0000);
        chk("R4 foreign slot3", {31'd0, own_hit}, 32'd0);
        slot_id = 3'd3;

        // R6 full mask exact match
        write_range(32'h8123_FFFF);
        set_addr(32'h8123_4567);
        chk("R6 full mask match", {31'd0, range_hit}, 32'd1);
        chk("R9 hit via range", {31'd0, hit}, 32'd1);
        set_addr(32'h8124_0000);
        chk("R6 full mask miss", {31'd0, range_hit}, 32'd0);
        set_addr(32'h0123_0000);
        chk("R6 bit31 compared", {31'd0, range_hit}, 32'd0);
        // R8 write strobe low keeps value
        @(negedge clk);
        cfg_wdata = 32'h0000_0000;
        set_addr(32'h8123_0000);
        chk("R8 no write without we", {31'd0, range_hit}, 32'd1);
        // R6 partial mask: compare bits 30:24 only
        write_range(32'h8100_FF00);
        set_addr(32'h81FF_0000);
        chk("R6 unmasked bits ignored", {31'd0, range_hit}, 32'd1);
        set_addr(32'h8200_0000);
        chk("R6 masked bit differs", {31'd0, range_hit}, 32'd0);
        // R6 enable clear
        write_range(32'h8123_7FFF);
        set_addr(32'h8123_0000);
        chk("R6 enable clear", {31'd0, range_hit}, 32'd0);
        // R7 reset clears a match-all range
        write_range(32'h0000_8000);
        set_addr(32'h0000_1234);
        chk("R6 match-all armed", {31'd0, range_hit}, 32'd1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R7 range cleared by reset", {31'd0, range_hit}, 32'd0);

        // R9 registered hit
        set_addr(32'h8800_0010);
        chk("R9 hit comb", {31'd0, hit}, 32'd1);
        set_addr(32'h0000_0010);
        chk("R9 hit_q follows", {31'd0, hit_q}, 32'd1);
        set_addr(32'h0000_0020);
        chk("R9 hit_q clears", {31'd0, hit_q}, 32'd0);

        // R10 remap
        host_addr = 32'h3600_0000;
        set_addr(32'h9E00_0000);
        chk("R10 host_to_bus", host_to_bus, 32'h9600_0000);
        chk("R10 bus_to_host", bus_to_host, 32'h3E00_0000);
        host_addr = 32'h2800_1234;
        #1;
        chk("R10 local remap", host_to_bus, 32'h8800_1234);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule